// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block runs the automatic flow control for one UART channel whose receive and transmit FIFOs hold 128 characters each. On the receive side it watches the receive FIFO fill level against two programmable thresholds. In hardware mode it drives an active-low RTS line with hysteresis. In software mode it asks the serializer to send the stop or go character, or a two-character sequence, to the far end.

Received characters pass through the block on their way to the receive FIFO. Characters that form a stop or go command are removed from the stream and reported on a discard strobe. They also pause or resume the local transmitter. Any character equal to a programmed special character raises a one-cycle detect flag. On the transmit side the block gates the serializer's data path. It does this from the synchronized CTS input and from the remote stop state. The gate closes only at a character boundary, and a pending flow character always goes out ahead of FIFO data.

Top module: `uart_flow_ctrl`

States of the receive-side machine: RX_OPEN, RX_OFF1 (first stop character offered), RX_OFF2 (second stop character offered), RX_HELD, RX_ON1 (first go character offered), RX_ON2 (second go character offered).

- RX_OPEN moves to RX_OFF1 when software flow is on and the level is at or above the high threshold.
- RX_OPEN moves straight to RX_HELD when only hardware flow is on.
- The RX_OFF states advance when the serializer takes the character. In pair mode RX_OFF1 goes to RX_OFF2, and RX_OFF2 then goes to RX_HELD.
- RX_HELD moves to RX_ON1 (software) or to RX_OPEN (hardware only) when the level is below the low threshold.
- The RX_ON states advance on each take in the same way and end in RX_OPEN.

States of the command matcher:
- M_IDLE evaluates each new character.
- M_HOLD keeps a possible first character of a pair. It leaves on the next character: a completed pair goes to M_IDLE, and a broken pair goes to M_FLUSH.
- M_FLUSH re-evaluates the character that broke the pair. It then goes to M_IDLE, or to M_HOLD if that character itself starts a pair.

States of the transmit gate:
- T_RUN moves to T_DRAIN on a stop request while a character is in flight, or to T_PAUSED if the serializer is idle.
- T_DRAIN moves to T_PAUSED when the character ends, or back to T_RUN if the request clears.
- T_PAUSED moves to T_RUN once the request clears.

## Requirements
- R1: After reset: rts_n is 0, tx_pause is 0, inj_valid is 0, rx_out_valid is 0, rx_discard is 0, spec_hit is 0, and tx_data_en is 1.
- R2: With hardware flow on, rts_n becomes 1 in the cycle after rx_level is at or above cfg_hi_thr. Thresholds from 1 to 128 are honoured, including 128 itself.
- R3: Once high, rts_n stays 1 while rx_level is at or above cfg_lo_thr. It returns to 0 in the cycle after rx_level drops below cfg_lo_thr.
- R4: With software flow on, a level at or above cfg_hi_thr makes the block offer cfg_xoff_a on inj_char with inj_valid. In pair mode it then offers cfg_xoff_b. Each character is held until ser_take_inj accepts it, and the block then advances.
- R5: After the stop has been sent, a level below cfg_lo_thr makes the block offer cfg_xon_a, and then cfg_xon_b in pair mode. A level equal to cfg_lo_thr offers nothing.
- R6: In single-character software mode, a received cfg_xoff_a or cfg_xon_a is not forwarded on rx_out_valid. It pulses rx_discard in the next cycle and sets (xoff) or clears (xon) the remote stop. Any other character is forwarded with one cycle of latency.
- R7: In pair mode, only cfg_xoff_a followed directly by cfg_xoff_b, or cfg_xon_a followed directly by cfg_xon_b, is a command; both characters are removed. If the second character does not complete the pair, the held first character is forwarded in the next cycle. The breaking character is then evaluated one cycle later and forwarded in that cycle unless it starts a new pair, in which case it is held.
- R8: With cfg_spec_en set, spec_hit pulses for one cycle in the cycle after a received character equals cfg_spec_char. It never pulses when cfg_spec_en is clear.
- R9: A stop request (from CTS or the remote stop) clears tx_data_en at once. tx_pause rises only when ser_busy is 0, so a character in flight always finishes. Both signals return to run once the request clears.
- R10: While inj_valid is 1, tx_data_en is 0, so a flow character goes out before the next FIFO data byte.
- R11: cts_n passes two synchronizing flops. A change on cts_n reaches tx_data_en after the second rising edge, not the first.
- R12: While inj_valid is 1 and ser_take_inj is 0, inj_valid and inj_char stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hw_flow | input | 1 | Enable RTS/CTS flow control |
| cfg_sw_flow | input | 1 | Enable character flow control |
| cfg_pair_mode | input | 1 | Use two-character xon/xoff sequences |
| cfg_spec_en | input | 1 | Enable special character detection |
| cfg_xon_a | input | 8 | First (or only) go character |
| cfg_xon_b | input | 8 | Second go character |
| cfg_xoff_a | input | 8 | First (or only) stop character |
| cfg_xoff_b | input | 8 | Second stop character |
| cfg_spec_char | input | 8 | Special character to match |
| cfg_hi_thr | input | 8 | High threshold, 1 to 128 |
| cfg_lo_thr | input | 8 | Low threshold, 1 to 128 |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| ser_busy | input | 1 | Serializer is shifting a character |
| ser_take_inj | input | 1 | Serializer accepts the injected character |
| rts_n | output | 1 | Request-to-send, active low |
| tx_pause | output | 1 | Transmitter paused at a character boundary |
| tx_data_en | output | 1 | Serializer may start a FIFO data character |
| inj_valid | output | 1 | A flow character is waiting to be sent |
| inj_char | output | 8 | The flow character to send |
| rx_out_valid | output | 1 | Forwarded data character strobe |
| rx_out_char | output | 8 | Forwarded data character |
| rx_discard | output | 1 | A flow command was received and dropped |
| spec_hit | output | 1 | Special character detected |

## Verification
The assertions take the configuration inputs as static while rst_n is high. They also assume rx_valid pulses are at least two cycles apart, as any real deserializer guarantees, and that ser_take_inj is raised only while inj_valid is 1 and ser_busy is 0. The bench keeps to these limits. It applies a fresh reset before each scenario and sets every configuration value while reset is held. It sends each received character as a single-cycle pulse followed by idle cycles. It raises ser_take_inj by hand only after it has seen inj_valid.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [2:0] {
        RX_OPEN,
        RX_OFF1,
        RX_OFF2,
        RX_HELD,
        RX_ON1,
        RX_ON2
    } rxf_state_t;

    typedef enum logic [1:0] {
        M_IDLE,
        M_HOLD,
        M_FLUSH
    } match_state_t;

    typedef enum logic [1:0] {
        T_RUN,
        T_DRAIN,
        T_PAUSED
    } txg_state_t;
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/flow_rx_fsm.sv
module flow_rx_fsm
    import flow_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_en,
    input  logic          sw_en,
    input  logic          pair,
    input  logic [DW-1:0] xon_a,
    input  logic [DW-1:0] xon_b,
    input  logic [DW-1:0] xoff_a,
    input  logic [DW-1:0] xoff_b,
    input  logic [CW-1:0] hi_thr,
    input  logic [CW-1:0] lo_thr,
    input  logic [CW-1:0] level,
    input  logic          take,
    output logic          rts_n,
    output logic          inj_valid,
    output logic [DW-1:0] inj_char
);
    rxf_state_t st, nx;
    logic above_hi, below_lo;

    assign above_hi = level >= hi_thr;
    assign below_lo = level < lo_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_OPEN;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            RX_OPEN: begin
                if (above_hi) begin
                    if (sw_en)      nx = RX_OFF1;
                    else if (hw_en) nx = RX_HELD;
                end
            end
            RX_OFF1: if (take) nx = pair ? RX_OFF2 : RX_HELD;
            RX_OFF2: if (take) nx = RX_HELD;
            RX_HELD: begin
                if (!hw_en && !sw_en) nx = RX_OPEN;
                else if (below_lo)    nx = sw_en ? RX_ON1 : RX_OPEN;
            end
            RX_ON1:  if (take) nx = pair ? RX_ON2 : RX_OPEN;
            RX_ON2:  if (take) nx = RX_OPEN;
            default: nx = RX_OPEN;
        endcase
    end

    always_comb begin
        rts_n     = 1'b0;
        inj_valid = 1'b0;
        inj_char  = '0;
        unique case (st)
            RX_OPEN: ;
            RX_OFF1: begin rts_n = hw_en; inj_valid = 1'b1; inj_char = xoff_a; end
            RX_OFF2: begin rts_n = hw_en; inj_valid = 1'b1; inj_char = xoff_b; end
            RX_HELD: rts_n = hw_en;
            RX_ON1:  begin inj_valid = 1'b1; inj_char = xon_a; end
            RX_ON2:  begin inj_valid = 1'b1; inj_char = xon_b; end
            default: ;
        endcase
    end
endmodule

// File: rtl/flow_rx_match.sv
module flow_rx_match
    import flow_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_en,
    input  logic          pair,
    input  logic          spec_en,
    input  logic [DW-1:0] xon_a,
    input  logic [DW-1:0] xon_b,
    input  logic [DW-1:0] xoff_a,
    input  logic [DW-1:0] xoff_b,
    input  logic [DW-1:0] spec_char,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    output logic          out_valid,
    output logic [DW-1:0] out_char,
    output logic          discard,
    output logic          spec_hit,
    output logic          remote_off
);
    match_state_t st, nx_st;
    logic [DW-1:0] held, nx_held, pend, nx_pend;
    logic [DW-1:0] nx_out_char, cand;
    logic          nx_out_valid, nx_discard, nx_remote, go;

    assign cand = (st == M_FLUSH) ? pend : rx_char;
    assign go   = (st == M_FLUSH) || (st == M_IDLE && rx_valid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= M_IDLE;
        else        st <= nx_st;
    end

    always_comb begin
        nx_st        = st;
        nx_held      = held;
        nx_pend      = pend;
        nx_out_valid = 1'b0;
        nx_out_char  = out_char;
        nx_discard   = 1'b0;
        nx_remote    = remote_off;
        unique case (st)
            M_IDLE, M_FLUSH: begin
                if (go) begin
                    nx_st = M_IDLE;
                    if (sw_en && pair && (cand == xon_a || cand == xoff_a)) begin
                        nx_held = cand;
                        nx_st   = M_HOLD;
                    end else if (sw_en && !pair && cand == xoff_a) begin
                        nx_discard = 1'b1;
                        nx_remote  = 1'b1;
                    end else if (sw_en && !pair && cand == xon_a) begin
                        nx_discard = 1'b1;
                        nx_remote  = 1'b0;
                    end else begin
                        nx_out_valid = 1'b1;
                        nx_out_char  = cand;
                    end
                end
            end
            M_HOLD: begin
                if (rx_valid) begin
                    if (held == xoff_a && rx_char == xoff_b) begin
                        nx_discard = 1'b1;
                        nx_remote  = 1'b1;
                        nx_st      = M_IDLE;
                    end else if (held == xon_a && rx_char == xon_b) begin
                        nx_discard = 1'b1;
                        nx_remote  = 1'b0;
                        nx_st      = M_IDLE;
                    end else begin
                        nx_out_valid = 1'b1;
                        nx_out_char  = held;
                        nx_pend      = rx_char;
                        nx_st        = M_FLUSH;
                    end
                end
            end
            default: nx_st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held       <= '0;
            pend       <= '0;
            out_valid  <= 1'b0;
            out_char   <= '0;
            discard    <= 1'b0;
            remote_off <= 1'b0;
            spec_hit   <= 1'b0;
        end else begin
            held       <= nx_held;
            pend       <= nx_pend;
            out_valid  <= nx_out_valid;
            out_char   <= nx_out_char;
            discard    <= nx_discard;
            remote_off <= nx_remote;
            spec_hit   <= spec_en && rx_valid && (rx_char == spec_char);
        end
    end
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic ser_busy,
    input  logic inj_pend,
    output logic tx_pause,
    output logic tx_data_en
);
    txg_state_t st, nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_RUN;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            T_RUN:    if (stop_req) nx = ser_busy ? T_DRAIN : T_PAUSED;
            T_DRAIN: begin
                if (!stop_req)     nx = T_RUN;
                else if (!ser_busy) nx = T_PAUSED;
            end
            T_PAUSED: if (!stop_req) nx = T_RUN;
            default:  nx = T_RUN;
        endcase
    end

    always_comb begin
        tx_pause   = 1'b0;
        tx_data_en = 1'b0;
        unique case (st)
            T_RUN:    tx_data_en = !stop_req && !inj_pend;
            T_DRAIN:  ;
            T_PAUSED: tx_pause = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_hw_flow,
    input  logic          cfg_sw_flow,
    input  logic          cfg_pair_mode,
    input  logic          cfg_spec_en,
    input  logic [DW-1:0] cfg_xon_a,
    input  logic [DW-1:0] cfg_xon_b,
    input  logic [DW-1:0] cfg_xoff_a,
    input  logic [DW-1:0] cfg_xoff_b,
    input  logic [DW-1:0] cfg_spec_char,
    input  logic [CW-1:0] cfg_hi_thr,
    input  logic [CW-1:0] cfg_lo_thr,
    input  logic [CW-1:0] rx_level,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    input  logic          cts_n,
    input  logic          ser_busy,
    input  logic          ser_take_inj,
    output logic          rts_n,
    output logic          tx_pause,
    output logic          tx_data_en,
    output logic          inj_valid,
    output logic [DW-1:0] inj_char,
    output logic          rx_out_valid,
    output logic [DW-1:0] rx_out_char,
    output logic          rx_discard,
    output logic          spec_hit
);
    logic cts_off, remote_off, stop_req;

    flow_cts_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n),
        .sync_out (cts_off)
    );

    flow_rx_fsm #(.CW(CW), .DW(DW)) u_rxf (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (cfg_hw_flow),
        .sw_en     (cfg_sw_flow),
        .pair      (cfg_pair_mode),
        .xon_a     (cfg_xon_a),
        .xon_b     (cfg_xon_b),
        .xoff_a    (cfg_xoff_a),
        .xoff_b    (cfg_xoff_b),
        .hi_thr    (cfg_hi_thr),
        .lo_thr    (cfg_lo_thr),
        .level     (rx_level),
        .take      (ser_take_inj),
        .rts_n     (rts_n),
        .inj_valid (inj_valid),
        .inj_char  (inj_char)
    );

    flow_rx_match #(.DW(DW)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_en      (cfg_sw_flow),
        .pair       (cfg_pair_mode),
        .spec_en    (cfg_spec_en),
        .xon_a      (cfg_xon_a),
        .xon_b      (cfg_xon_b),
        .xoff_a     (cfg_xoff_a),
        .xoff_b     (cfg_xoff_b),
        .spec_char  (cfg_spec_char),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .out_valid  (rx_out_valid),
        .out_char   (rx_out_char),
        .discard    (rx_discard),
        .spec_hit   (spec_hit),
        .remote_off (remote_off)
    );

    assign stop_req = (cfg_hw_flow && cts_off) || (cfg_sw_flow && remote_off);

    flow_tx_gate u_txg (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .ser_busy   (ser_busy),
        .inj_pend   (inj_valid),
        .tx_pause   (tx_pause),
        .tx_data_en (tx_data_en)
    );
endmodule

// File: rtl/flow_chk.sv
module flow_chk #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_hw_flow,
    input logic          cfg_sw_flow,
    input logic          cfg_pair_mode,
    input logic          cfg_spec_en,
    input logic [DW-1:0] cfg_xon_a,
    input logic [DW-1:0] cfg_xoff_a,
    input logic [CW-1:0] cfg_hi_thr,
    input logic [CW-1:0] cfg_lo_thr,
    input logic [CW-1:0] rx_level,
    input logic          rx_valid,
    input logic          ser_busy,
    input logic          ser_take_inj,
    input logic          rts_n,
    input logic          tx_pause,
    input logic          tx_data_en,
    input logic          inj_valid,
    input logic [DW-1:0] inj_char,
    input logic          rx_out_valid,
    input logic [DW-1:0] rx_out_char,
    input logic          spec_hit
);
    AST_RTS_OFF_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(cfg_hw_flow)) |-> ($past(rx_level) >= $past(cfg_hi_thr))); // R2

    AST_RTS_ON_BELOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rts_n) && cfg_hw_flow && $past(cfg_hw_flow)) |-> ($past(rx_level) < $past(cfg_lo_thr))); // R3

    AST_CMD_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && cfg_sw_flow && !cfg_pair_mode) |-> (rx_out_char != cfg_xon_a && rx_out_char != cfg_xoff_a)); // R6

    AST_SPEC_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        spec_hit |-> ($past(rx_valid) && $past(cfg_spec_en))); // R8

    AST_PAUSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(!ser_busy)); // R9

    AST_INJ_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !tx_data_en); // R10

    AST_INJ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !ser_take_inj) |=> (inj_valid && $stable(inj_char))); // R12
endmodule

bind uart_flow_ctrl flow_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_hw_flow   (cfg_hw_flow),
    .cfg_sw_flow   (cfg_sw_flow),
    .cfg_pair_mode (cfg_pair_mode),
    .cfg_spec_en   (cfg_spec_en),
    .cfg_xon_a     (cfg_xon_a),
    .cfg_xoff_a    (cfg_xoff_a),
    .cfg_hi_thr    (cfg_hi_thr),
    .cfg_lo_thr    (cfg_lo_thr),
    .rx_level      (rx_level),
    .rx_valid      (rx_valid),
    .ser_busy      (ser_busy),
    .ser_take_inj  (ser_take_inj),
    .rts_n         (rts_n),
    .tx_pause      (tx_pause),
    .tx_data_en    (tx_data_en),
    .inj_valid     (inj_valid),
    .inj_char      (inj_char),
    .rx_out_valid  (rx_out_valid),
    .rx_out_char   (rx_out_char),
    .spec_hit      (spec_hit)
);

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_hw_flow = 1'b0, cfg_sw_flow = 1'b0, cfg_pair_mode = 1'b0, cfg_spec_en = 1'b0;
    logic [7:0] cfg_xon_a = 8'h11, cfg_xon_b = 8'h12, cfg_xoff_a = 8'h13, cfg_xoff_b = 8'h14;
    logic [7:0] cfg_spec_char = 8'h7E, cfg_hi_thr = 8'd100, cfg_lo_thr = 8'd20;
    logic [7:0] rx_level = '0, rx_char = '0;
    logic       rx_valid = 1'b0, cts_n = 1'b0, ser_busy = 1'b0, ser_take_inj = 1'b0;
    logic       rts_n, tx_pause, tx_data_en, inj_valid, rx_out_valid, rx_discard, spec_hit;
    logic [7:0] inj_char, rx_out_char;
    int         vecs = 0, bad = 0;

    always #2 clk = ~clk;

    uart_flow_ctrl u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic hw, input logic sw, input logic pr, input logic sp,
                            input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_hw_flow = hw; cfg_sw_flow = sw; cfg_pair_mode = pr; cfg_spec_en = sp;
        cfg_hi_thr = hi; cfg_lo_thr = lo;
        rx_level = '0; rx_valid = 1'b0; cts_n = 1'b0; ser_busy = 1'b0; ser_take_inj = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic send(input logic [7:0] c);
        rx_valid = 1'b1; rx_char = c;
        step(1);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b1, 1'b1, 1'b0, 1'b1, 8'd100, 8'd20);
        check("R1 rts_n", rts_n, 0);
        check("R1 tx_pause", tx_pause, 0);
        check("R1 inj_valid", inj_valid, 0);
        check("R1 rx_out_valid", rx_out_valid, 0);
        check("R1 rx_discard", rx_discard, 0);
        check("R1 spec_hit", spec_hit, 0);
        check("R1 tx_data_en", tx_data_en, 1);
    endtask

    task automatic t_hw_hyst;
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 8'd100, 8'd20);
        rx_level = 99;  step(1); check("R2 below high", rts_n, 0);
        rx_level = 100; step(1); check("R2 at high", rts_n, 1);
        rx_level = 50;  step(1); check("R3 middle", rts_n, 1);
        rx_level = 20;  step(1); check("R3 at low", rts_n, 1);
        rx_level = 19;  step(1); check("R3 below low", rts_n, 0);
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 8'd128, 8'd1);
        rx_level = 127; step(1); check("R2 thr128 below", rts_n, 0);
        rx_level = 128; step(1); check("R2 thr128 at", rts_n, 1);
        rx_level = 1;   step(1); check("R3 thr1 at", rts_n, 1);
        rx_level = 0;   step(1); check("R3 thr1 below", rts_n, 0);
    endtask

    task automatic t_sw_inject;
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 8'd100, 8'd10);
        rx_level = 100; step(1);
        check("R4 xoff_a valid", inj_valid, 1);
        check("R4 xoff_a char", inj_char, 8'h13);
        check("R10 data blocked", tx_data_en, 0);
        ser_take_inj = 1'b1; step(1); ser_take_inj = 1'b0;
        check("R4 xoff_b char", inj_char, 8'h14);
        step(2);
        check("R12 held valid", inj_valid, 1);
        check("R12 held char", inj_char, 8'h14);
        ser_take_inj = 1'b1; step(1); ser_take_inj = 1'b0;
        check("R4 stop done", inj_valid, 0);
        check("R10 data open", tx_data_en, 1);
        rx_level = 10; step(1); check("R5 at low no xon", inj_valid, 0);
        rx_level = 9;  step(1);
        check("R5 xon_a valid", inj_valid, 1);
        check("R5 xon_a char", inj_char, 8'h11);
        ser_take_inj = 1'b1; step(1);
        check("R5 xon_b char", inj_char, 8'h12);
        step(1); ser_take_inj = 1'b0;
        check("R5 go done", inj_valid, 0);
    endtask

    task automatic t_rx_single;
        do_reset(1'b0, 1'b1, 1'b0, 1'b0, 8'd100, 8'd10);
        send(8'h13);
        check("R6 xoff discard", rx_discard, 1);
        check("R6 xoff not fwd", rx_out_valid, 0);
        check("R9 data stopped", tx_data_en, 0);
        step(1);
        check("R9 paused idle", tx_pause, 1);
        send(8'h41);
        check("R6 data fwd", rx_out_valid, 1);
        check("R6 data char", rx_out_char, 8'h41);
        step(1);
        send(8'h11);
        check("R6 xon discard", rx_discard, 1);
        check("R6 xon not fwd", rx_out_valid, 0);
        step(1);
        check("R9 resumed pause", tx_pause, 0);
        check("R9 resumed data", tx_data_en, 1);
    endtask

    task automatic t_rx_pair;
        do_reset(1'b0, 1'b1, 1'b1, 1'b0, 8'd100, 8'd10);
        send(8'h13);
        check("R7 first held", rx_out_valid, 0);
        check("R7 first no discard", rx_discard, 0);
        step(2);
        send(8'h14);
        check("R7 pair discard", rx_discard, 1);
        check("R7 pair not fwd", rx_out_valid, 0);
        step(1);
        check("R7 pair pauses", tx_pause, 1);
        send(8'h11);
        step(2);
        send(8'h55);
        check("R7 broken held fwd", rx_out_valid, 1);
        check("R7 broken held char", rx_out_char, 8'h11);
        step(1);
        check("R7 breaker fwd", rx_out_valid, 1);
        check("R7 breaker char", rx_out_char, 8'h55);
        check("R7 still paused", tx_pause, 1);
        step(2);
        send(8'h11);
        step(2);
        send(8'h12);
        check("R7 xon pair discard", rx_discard, 1);
        step(1);
        check("R7 xon pair resumes", tx_pause, 0);
    endtask

    task automatic t_cts;
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 8'd100, 8'd20);
        ser_busy = 1'b1; cts_n = 1'b1;
        step(1); check("R11 one flop", tx_data_en, 1);
        step(1); check("R11 two flops", tx_data_en, 0);
        check("R9 no pause busy", tx_pause, 0);
        step(2); check("R9 drain busy", tx_pause, 0);
        ser_busy = 1'b0;
        step(1); check("R9 pause at boundary", tx_pause, 1);
        cts_n = 1'b0;
        step(3);
        check("R9 cts resume pause", tx_pause, 0);
        check("R9 cts resume data", tx_data_en, 1);
    endtask

    task automatic t_spec;
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 8'd100, 8'd20);
        send(8'h7E);
        check("R8 match", spec_hit, 1);
        check("R8 match fwd", rx_out_valid, 1);
        step(1); check("R8 one cycle", spec_hit, 0);
        send(8'h7F);
        check("R8 miss", spec_hit, 0);
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 8'd100, 8'd20);
        send(8'h7E);
        check("R8 disabled", spec_hit, 0);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_hw_hyst();
        t_sw_inject();
        t_rx_single();
        t_rx_pair();
        t_cts();
        t_spec();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule